// File: doc/BRIEF.md
# Two-Wire Bus Master Byte Engine

This block is the master side of a two-wire serial bus controller in the SMBus/I2C style. Software loads the data register with a 7-bit target address followed by the direction bit in the least significant position, then requests a START. The block waits until both lines have been high for a fixed number of cycles, issues the START, and shifts the address out. From then on it moves one byte per software handshake. An interrupt flag is raised at the end of every frame and stays set until software clears it. While the flag is set, the block holds SCL low.

The interrupt comes at different points in the two directions. When transmitting, the flag rises after the ninth clock, so the acknowledge returned by the target is already in the ACK bit. When receiving, the flag rises after the eighth data bit and before the ninth clock, so software can choose ACK or NACK first. If software clears a transmit interrupt without writing a new byte, the block receives a byte instead.

Both lines are open-drain: an output enable pulls a line low, and the sampled input shows the wired bus level. SCL timing comes from a programmable divider, and the block waits while another device holds SCL low. If the block leaves SDA released on a transmitted bit but samples it low, it stops at once, releases both lines and reports lost arbitration.

Top module: `smb_master`

## Requirements
- R1: After a synchronous reset, scl_oe, sda_oe, irq, arb_lost and busy are all 0.
- R2: When a start request is pending and the bus has been idle, SDA is pulled low while SCL is high. The data register is then sent MSB first, and its bit 0 is the direction bit (1 means read). busy is 1 from the START onwards.
- R3: During data and acknowledge bits, sda_oe changes only while SCL is low. The only changes to sda_oe while SCL is high are the falling edge of START and the rising edge of STOP.
- R4: In transmit mode, irq rises after the ninth clock of the frame. ack_bit is then 1 if SDA was low on that clock (ACK) and 0 if it was high (NACK). irq stays 1 until irq_clr is pulsed.
- R5: A byte written to the data register while a transmit interrupt is pending, with direction bit 0, is the next byte sent once irq_clr is pulsed.
- R6: If the address had direction bit 1, or no byte was written before a transmit interrupt was cleared, the next frame is received and tx_mode reads 0.
- R7: In receive mode, irq rises after the eighth bit and before the ninth clock. SCL is held low while irq is pending, and dat_rd shows the received byte MSB first.
- R8: On the ninth clock of a received byte, the block pulls SDA low when ack_bit is 1 and leaves SDA released when ack_bit is 0.
- R9: A stop request that is pending when the interrupt is cleared produces a STOP: SDA rises while SCL is high. After the STOP, busy is 0 and both lines are released.
- R10: If SDA reads low on a transmitted 1 bit while SCL is high, the block releases both lines and sets busy to 0. It sets arb_lost and irq together. irq_clr clears both flags.
- R11: A start request that is pending when the interrupt is cleared produces a repeated START without a STOP, followed by the new contents of the data register as the address.
- R12: A synchronous reset in the middle of a frame returns the block to idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dat_we | input | 1 | Write strobe for the data register |
| dat_wval | input | 8 | Value written to the data register |
| sta_set | input | 1 | Sets the start request |
| sto_set | input | 1 | Sets the stop request |
| ack_we | input | 1 | Write strobe for the ACK bit |
| ack_wval | input | 1 | Value for the ACK bit (1 = acknowledge) |
| irq_clr | input | 1 | Clears the interrupt and arbitration flags and resumes the sequence |
| dat_rd | output | 8 | Data register contents, including the last received byte |
| ack_bit | output | 1 | ACK bit: the captured target acknowledge, or the value to send |
| irq | output | 1 | Byte-done interrupt flag |
| arb_lost | output | 1 | Arbitration-lost flag |
| busy | output | 1 | Master mode active |
| tx_mode | output | 1 | 1 when transmitting, 0 when receiving |
| scl_in | input | 1 | Sampled SCL bus level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |
| sda_oe | output | 1 | Pulls SDA low when 1 |

## Verification
The assertions assume that scl_in and sda_in are the wired-AND of this block's own releases with the other devices on the bus. They also assume that no other device drives SDA while this block is still pulling it low at a frame boundary. The bench builds both lines from the output enables, a target model and one extra pull-down that stands in for a competing master. The target model changes SDA only on falling SCL edges. It stops sending after it sees a NACK, and the competing pull-down is raised only once the START has been seen.

// File: rtl/smb_master.sv
module smb_master #(
  parameter int DIV  = 8,
  parameter int FREE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dat_we,
  input  logic [7:0] dat_wval,
  input  logic       sta_set,
  input  logic       sto_set,
  input  logic       ack_we,
  input  logic       ack_wval,
  input  logic       irq_clr,
  output logic [7:0] dat_rd,
  output logic       ack_bit,
  output logic       irq,
  output logic       arb_lost,
  output logic       busy,
  output logic       tx_mode,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FW = $clog2(FREE + 1);

  typedef enum logic [2:0] {S_IDLE, S_STA, S_BIT, S_ACK, S_HOLD, S_STO} st_t;

  st_t           st;
  logic [1:0]    q;
  logic [CW-1:0] cnt;
  logic [FW-1:0] idle_cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh, dat;
  logic          rdir, pend_ack, wrote, sta_q, sto_q;

  assign dat_rd = dat;

  wire run   = (st == S_STA) || (st == S_BIT) || (st == S_ACK) || (st == S_STO);
  wire stall = !scl_oe && !scl_in;
  wire tick  = run && !stall && (cnt == CW'(DIV - 1));
  wire lose  = tick && (st == S_BIT) && (q == 2'd2) && tx_mode && !sda_oe && !sda_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; q <= '0; cnt <= '0; idle_cnt <= '0; bitn <= '0;
      sh <= '0; dat <= '0; rdir <= 1'b0; pend_ack <= 1'b0; wrote <= 1'b0;
      sta_q <= 1'b0; sto_q <= 1'b0; ack_bit <= 1'b0; irq <= 1'b0;
      arb_lost <= 1'b0; busy <= 1'b0; tx_mode <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (dat_we) begin dat <= dat_wval; wrote <= 1'b1; end
      if (sta_set) sta_q <= 1'b1;
      if (sto_set) sto_q <= 1'b1;
      if (ack_we) ack_bit <= ack_wval;
      if (irq_clr && st != S_HOLD) begin irq <= 1'b0; arb_lost <= 1'b0; end

      if (!run) cnt <= '0;
      else if (!stall) cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) q <= q + 1'b1;

      if (scl_in && sda_in) begin
        if (idle_cnt != FW'(FREE)) idle_cnt <= idle_cnt + 1'b1;
      end else idle_cnt <= '0;

      case (st)
        S_IDLE:
          if (sta_q && idle_cnt == FW'(FREE)) begin
            st <= S_STA; sta_q <= 1'b0; busy <= 1'b1; q <= '0;
          end
        S_STA:
          if (tick) begin
            case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1; st <= S_BIT; bitn <= 3'd7; sh <= dat;
                tx_mode <= 1'b1; rdir <= dat[0]; pend_ack <= 1'b0;
              end
            endcase
          end
        S_BIT:
          if (tick) begin
            case (q)
              2'd0: sda_oe <= tx_mode && !sh[7];
              2'd1: scl_oe <= 1'b0;
              2'd2: sh <= {sh[6:0], sda_in};
              default: begin
                scl_oe <= 1'b1;
                if (bitn != 3'd0) bitn <= bitn - 1'b1;
                else if (tx_mode) st <= S_ACK;
                else begin
                  st <= S_HOLD; irq <= 1'b1; pend_ack <= 1'b1; wrote <= 1'b0; dat <= sh;
                end
              end
            endcase
          end
        S_ACK:
          if (tick) begin
            case (q)
              2'd0: sda_oe <= !tx_mode && ack_bit;
              2'd1: scl_oe <= 1'b0;
              2'd2: if (tx_mode) ack_bit <= !sda_in;
              default: begin
                scl_oe <= 1'b1;
                if (tx_mode) begin
                  st <= S_HOLD; irq <= 1'b1; wrote <= 1'b0;
                end else if (sto_q) st <= S_STO;
                else if (sta_q) begin st <= S_STA; sta_q <= 1'b0; end
                else begin st <= S_BIT; bitn <= 3'd7; end
              end
            endcase
          end
        S_HOLD:
          if (irq_clr) begin
            irq <= 1'b0;
            if (pend_ack) begin st <= S_ACK; pend_ack <= 1'b0; end
            else if (sto_q) st <= S_STO;
            else if (sta_q) begin st <= S_STA; sta_q <= 1'b0; end
            else if (!rdir && wrote) begin st <= S_BIT; bitn <= 3'd7; sh <= dat; end
            else begin st <= S_BIT; bitn <= 3'd7; tx_mode <= 1'b0; end
          end
        S_STO:
          if (tick) begin
            case (q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin
                sda_oe <= 1'b0; st <= S_IDLE; busy <= 1'b0; sto_q <= 1'b0;
              end
            endcase
          end
        default: st <= S_IDLE;
      endcase

      if (lose) begin
        st <= S_IDLE; q <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
        arb_lost <= 1'b1; irq <= 1'b1; busy <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      end
    end
  end

  p_reset_idle_r12: assert property (@(posedge clk)
    rst |=> (!busy && !scl_oe && !sda_oe && !irq && !arb_lost));

  p_sda_low_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && (st == S_BIT || st == S_ACK)) |=> (scl_oe || sda_oe == $past(sda_oe)));

  p_irq_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  p_hold_scl_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD) |-> scl_oe);

  p_lose_release_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> (!scl_oe && !sda_oe && !busy && irq));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/smb_master_tb_top.sv
module smb_master_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic dat_we = 0, sta_set = 0, sto_set = 0, ack_we = 0, ack_wval = 0, irq_clr = 0;
  logic [7:0] dat_wval = 0;
  logic [7:0] dat_rd;
  logic ack_bit, irq, arb_lost, busy, tx_mode, scl_oe, sda_oe;
  logic s_low = 0, other_low = 0;
  wire scl_bus = !scl_oe;
  wire sda_bus = !(sda_oe || s_low || other_low);

  smb_master #(.DIV(4), .FREE(8)) dut_i (
    .clk(clk), .rst(rst), .dat_we(dat_we), .dat_wval(dat_wval),
    .sta_set(sta_set), .sto_set(sto_set), .ack_we(ack_we), .ack_wval(ack_wval),
    .irq_clr(irq_clr), .dat_rd(dat_rd), .ack_bit(ack_bit), .irq(irq),
    .arb_lost(arb_lost), .busy(busy), .tx_mode(tx_mode),
    .scl_in(scl_bus), .scl_oe(scl_oe), .sda_in(sda_bus), .sda_oe(sda_oe));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: expected bytes seen by the target model
  logic [7:0] exp_q[$];
  task automatic push_exp(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  // target model
  logic scl_p = 1, sda_p = 1;
  int bc = 0, starts = 0, stops = 0, frames = 0;
  bit sl_tx = 0, first = 0, m_ack = 0, ack_en = 1;
  logic [7:0] sr = 0, txb = 8'h96;

  always @(posedge clk) begin
    scl_p <= scl_bus;
    sda_p <= sda_bus;
    if (rst) begin
      s_low <= 0; bc = 0; sl_tx = 0; first = 0;
    end else if (scl_bus && scl_p && sda_p && !sda_bus) begin
      starts++; bc = 0; first = 1; sl_tx = 0; s_low <= 0;
    end else if (scl_bus && scl_p && !sda_p && sda_bus) begin
      stops++; bc = 0; sl_tx = 0; s_low <= 0;
    end else if (scl_bus && !scl_p) begin
      if (bc < 8) begin
        sr = {sr[6:0], sda_bus};
        bc++;
        if (bc == 8 && !sl_tx) begin
          // R5: monitor pops and compares each byte the target received
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R5 actual=%0h expected=none", sr);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (e != sr) begin
              errors++;
              $display("FAIL R5 actual=%0h expected=%0h", sr, e);
            end
          end
        end
      end else begin
        m_ack = !sda_bus;
        bc = 0;
        frames++;
        if (first) begin first = 0; sl_tx = sr[0]; end
        else if (sl_tx) begin txb = txb + 1; if (!m_ack) sl_tx = 0; end
      end
    end else if (!scl_bus && scl_p) begin
      if (bc == 8) s_low <= !sl_tx && ack_en;
      else if (sl_tx) s_low <= !txb[7 - bc];
      else s_low <= 0;
    end
  end

  // R3 monitor: sda_oe changes while SCL stays high
  int hi_chg = 0;
  bit quiet = 0;
  logic so_n = 0, sc_n = 1;
  always @(negedge clk) begin
    if (!quiet && scl_bus && sc_n && sda_oe != so_n) hi_chg++;
    so_n <= sda_oe;
    sc_n <= scl_bus;
  end

  task automatic pulse_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1; dat_wval = v;
    @(negedge clk); dat_we = 0;
  endtask
  task automatic pulse_sta();
    @(negedge clk); sta_set = 1; @(negedge clk); sta_set = 0;
  endtask
  task automatic pulse_sto();
    @(negedge clk); sto_set = 1; @(negedge clk); sto_set = 0;
  endtask
  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask
  task automatic set_ack(input logic v);
    @(negedge clk); ack_we = 1; ack_wval = v; @(negedge clk); ack_we = 0;
  endtask
  task automatic wait_irq(input string req);
    int n = 0;
    @(negedge clk);
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk(irq, req, irq, 1);
  endtask
  task automatic wait_idle(input string req);
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, req, busy, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !irq && !arb_lost && !busy, "R1",
        {scl_oe, sda_oe, irq, arb_lost, busy}, 0);

    // write transfer: address, two bytes (second NACKed), stop
    pulse_dat(8'hA0); push_exp(8'hA0);
    pulse_sta();
    wait_irq("R4");
    chk(starts == 1 && busy, "R2", starts, 1);
    chk(ack_bit == 1 && tx_mode, "R4", ack_bit, 1);
    chk(frames == 1 && bc == 0 && scl_oe, "R4", frames, 1);
    pulse_dat(8'h3C); push_exp(8'h3C);
    pulse_clr();
    wait_irq("R5");
    chk(frames == 2 && ack_bit == 1, "R5", frames, 2);
    ack_en = 0;
    pulse_dat(8'hC5); push_exp(8'hC5);
    pulse_clr();
    wait_irq("R4");
    chk(ack_bit == 0, "R4", ack_bit, 0);
    ack_en = 1;
    pulse_sto();
    pulse_clr();
    wait_idle("R9");
    repeat (2) @(negedge clk);
    chk(stops == 1 && !scl_oe && !sda_oe && sda_bus && scl_bus, "R9", stops, 1);

    // read transfer: two bytes, ACK then NACK
    pulse_dat(8'hA1); push_exp(8'hA1);
    pulse_sta();
    wait_irq("R2");
    chk(ack_bit == 1, "R2", ack_bit, 1);
    pulse_clr();
    wait_irq("R7");
    chk(dat_rd == 8'h96, "R7", dat_rd, 8'h96);
    chk(!tx_mode, "R6", tx_mode, 0);
    chk(scl_oe && bc == 8, "R7", bc, 8);
    repeat (40) @(negedge clk);
    chk(scl_oe && irq && bc == 8, "R7", scl_oe, 1);
    set_ack(1);
    pulse_clr();
    wait_irq("R8");
    chk(m_ack == 1, "R8", m_ack, 1);
    chk(dat_rd == 8'h97, "R7", dat_rd, 8'h97);
    set_ack(0);
    pulse_sto();
    pulse_clr();
    wait_idle("R9");
    chk(m_ack == 0, "R8", m_ack, 0);
    repeat (2) @(negedge clk);
    chk(stops == 2, "R9", stops, 2);

    // write direction with no new data, then repeated start
    pulse_dat(8'hA0); push_exp(8'hA0);
    pulse_sta();
    wait_irq("R4");
    push_exp(8'hFF);
    pulse_clr();
    wait_irq("R6");
    chk(!tx_mode && dat_rd == 8'hFF, "R6", dat_rd, 8'hFF);
    pulse_dat(8'hA0); push_exp(8'hA0);
    set_ack(0);
    pulse_sta();
    pulse_clr();
    wait_irq("R11");
    chk(starts == 4 && stops == 2, "R11", starts, 4);
    chk(tx_mode && ack_bit == 1, "R11", ack_bit, 1);
    pulse_sto();
    pulse_clr();
    wait_idle("R9");

    // arbitration loss on the first address bit
    repeat (20) @(negedge clk);
    pulse_dat(8'h80);
    pulse_sta();
    begin
      int n = 0;
      while (starts < 5 && n < 5000) begin @(negedge clk); n++; end
    end
    other_low = 1;
    wait_irq("R10");
    chk(arb_lost && !busy && !scl_oe && !sda_oe, "R10",
        {arb_lost, busy, scl_oe, sda_oe}, 4'b1000);
    other_low = 0;
    repeat (4) @(negedge clk);
    pulse_clr();
    @(negedge clk);
    chk(!arb_lost && !irq, "R10", arb_lost, 0);

    // synchronous reset in the middle of a frame
    repeat (20) @(negedge clk);
    pulse_dat(8'hA0);
    pulse_sta();
    begin
      int n = 0;
      while (starts < 6 && n < 5000) begin @(negedge clk); n++; end
    end
    repeat (30) @(negedge clk);
    chk(busy, "R12", busy, 1);
    quiet = 1;
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe && !irq, "R12", {busy, scl_oe, sda_oe, irq}, 0);
    repeat (4) @(negedge clk);
    quiet = 0;

    chk(hi_chg == 9, "R3", hi_chg, 9);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule